// File: doc/BRIEF.md
# Hierarchical Interrupt Status Controller

This block gathers interrupt events from four device sections and turns them into one active-low interrupt line. Each section owns a status register and an enable register of equal width. A one-cycle pulse on an event input sets the matching status bit, and the bit stays set until the host clears it. This holds even for conditions the hardware recovers from by itself, so a later occurrence is still reported. The enable register has the same bit layout as the status register and decides which latched events may raise an interrupt.

A small global summary vector carries one bit per section. Each bit is computed live from that section's status and enable registers, so it needs no acknowledge. It drops as soon as the section's pending enabled events are cleared or disabled. The host reads the summary first, whether it was woken by the interrupt line or is polling, to find the responsible section. It then inspects and clears that section's status register. The host bus bridge is outside this block: it presents per-section clear and enable write strobes with a shared write word, and it reads the registers through plain output buses. All pins are plain control and status signals, and no data stream passes through the block.

Top module: `irq_hier_ctrl`

## Requirements
- R1: A status bit is set on the clock edge where its event input is 1 and is visible in `sts_o` after that edge. A status bit never becomes 1 unless its event input was 1 in the previous cycle.
- R2: When `clr_we_i[s]` is 1, every status bit of section s whose `wdata_i` bit is 1 is cleared at that edge. Bits whose `wdata_i` bit is 0 keep their value.
- R3: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Status bits latch events even while their enable bit is 0. Enabling such a bit later raises the section's summary bit in the cycle right after the enable write.
- R5: When `en_we_i[s]` is 1, section s's enable register takes `wdata_i` at that edge, bit for bit at the same positions as the status bits. An enable write never changes a status bit.
- R6: `glob_o[s]` is the OR over section s's status bits ANDed with their enables, with no delay beyond the registers. The section order is bit 0 link layer, bit 1 AV transmitter, bit 2 AV receiver, bit 3 asynchronous transceiver.
- R7: A summary bit needs no acknowledge. It is 0 in the cycle after the last enabled pending status bit of its section is cleared or disabled.
- R8: `irq_n_o` is a register. It is 0 in the cycle after any summary bit is 1, and 1 in the cycle after all summary bits are 0.
- R9: During and after reset, all status and enable bits are 0, `glob_o` is 0 and `irq_n_o` is 1.
- R10: A clear or enable write to one section leaves the status and enable registers of every other section unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSEC*SW | One-cycle event pulses; section s occupies bits [s*SW +: SW] |
| clr_we_i | input | NSEC | Per-section write-one-to-clear strobe for the status register |
| en_we_i | input | NSEC | Per-section write strobe for the enable register |
| wdata_i | input | SW | Write word shared by all strobes |
| sts_o | output | NSEC*SW | Status registers, same packing as `evt_i` |
| ena_o | output | NSEC*SW | Enable registers, same packing as `evt_i` |
| glob_o | output | NSEC | Live per-section summary bits |
| irq_n_o | output | 1 | Registered active-low interrupt line |

## Verification
The assertions assume that the event inputs, strobes and write word are synchronous to `clk` and held at 0 while reset is active. They also assume that `wdata_i` is only meaningful in a cycle where some strobe is high. The bench drives every input on the falling edge and returns all of them to 0 after each cycle, so these assumptions always hold. Same-cycle event and clear collisions are produced deliberately so that the priority rule is exercised inside these limits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSEC_DEF = 4;
  localparam int SW_DEF   = 8;

  typedef enum logic [1:0] {
    SEC_LINK = 2'd0,
    SEC_ATX  = 2'd1,
    SEC_ARX  = 2'd2,
    SEC_ASY  = 2'd3
  } sect_e;
endpackage

// File: rtl/irq_sect.sv
module irq_sect #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] evt_i,
  input  logic          clr_we_i,
  input  logic          en_we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] sts_o,
  output logic [SW-1:0] ena_o,
  output logic          sum_o
);
  logic [SW-1:0] sts_q, ena_q, clr_mask, sts_d;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    sts_d    = (sts_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_we_i) ena_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign ena_o = ena_q;
  assign sum_o = |(sts_q & ena_q);

  // R1 and R3: an event always leaves its bit set, even against a clear
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(evt_i)) == $past(evt_i)));
  // R1: no bit rises without an event
  a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_i)) == '0));
  // R2: a bit only falls where the host wrote a one through the clear strobe
  a_r2_clear_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~sts_q & $past(sts_q) & ~($past(clr_we_i) ? $past(wdata_i) : '0)) == '0));
  // R5: an enable write lands exactly
  a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (ena_o == $past(wdata_i)));
  // R5: enable keeps its value when not written
  a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(ena_o));
endmodule

// File: rtl/irq_pin.sv
module irq_pin #(
  parameter int NSEC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEC-1:0] glob_i,
  output logic            irq_n_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~(|glob_i);
  end

  // R8: pin follows the summary one cycle later
  a_r8_assert_low: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_i != '0) |=> !irq_n_o);
  a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_i == '0) |=> irq_n_o);
endmodule

// File: rtl/irq_hier_ctrl.sv
module irq_hier_ctrl
  import irq_pkg::*;
#(
  parameter int NSEC = NSEC_DEF,
  parameter int SW   = SW_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSEC*SW-1:0] evt_i,
  input  logic [NSEC-1:0]    clr_we_i,
  input  logic [NSEC-1:0]    en_we_i,
  input  logic [SW-1:0]      wdata_i,
  output logic [NSEC*SW-1:0] sts_o,
  output logic [NSEC*SW-1:0] ena_o,
  output logic [NSEC-1:0]    glob_o,
  output logic               irq_n_o
);
  localparam int TOTW = NSEC * SW;

  logic [NSEC-1:0] sum;

  for (genvar s = 0; s < NSEC; s++) begin : g_sect
    irq_sect #(.SW(SW)) i_sect (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[s*SW +: SW]),
      .clr_we_i (clr_we_i[s]),
      .en_we_i  (en_we_i[s]),
      .wdata_i  (wdata_i),
      .sts_o    (sts_o[s*SW +: SW]),
      .ena_o    (ena_o[s*SW +: SW]),
      .sum_o    (sum[s])
    );

    // R10: a strobe aimed elsewhere leaves this section's registers alone
    a_r10_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_we_i[s] && !clr_we_i[s] && evt_i[s*SW +: SW] == '0)
        |=> $stable(sts_o[s*SW +: SW]) && $stable(ena_o[s*SW +: SW]));
  end

  assign glob_o = sum;

  irq_pin #(.NSEC(NSEC)) i_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .glob_i  (glob_o),
    .irq_n_o (irq_n_o)
  );

  // R6: summary agrees with the full register view
  a_r6_summary_live: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_o != '0) == ((sts_o & ena_o) != {TOTW{1'b0}}));
  // R9: no pending interrupt right after reset release
  a_r9_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (sts_o == '0) && (ena_o == '0) && irq_n_o);
endmodule

// File: tb/test_irq_hier_ctrl.sv
`timescale 1ns/1ps
module test_irq_hier_ctrl;
  localparam int NSEC = 4;
  localparam int SW   = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NSEC*SW-1:0] evt_i = '0;
  logic [NSEC-1:0]    clr_we_i = '0;
  logic [NSEC-1:0]    en_we_i = '0;
  logic [SW-1:0]      wdata_i = '0;
  logic [NSEC*SW-1:0] sts_o, ena_o;
  logic [NSEC-1:0]    glob_o;
  logic               irq_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [SW-1:0] m_sts [NSEC];
  logic [SW-1:0] m_ena [NSEC];
  logic          m_irqn;

  always #2 clk = ~clk;

  irq_hier_ctrl #(.NSEC(NSEC), .SW(SW)) i_irq_hier_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_we_i(clr_we_i),
    .en_we_i(en_we_i), .wdata_i(wdata_i), .sts_o(sts_o), .ena_o(ena_o),
    .glob_o(glob_o), .irq_n_o(irq_n_o)
  );

  function automatic logic [NSEC-1:0] m_glob();
    logic [NSEC-1:0] g;
    for (int s = 0; s < NSEC; s++) g[s] = |(m_sts[s] & m_ena[s]);
    return g;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int s = 0; s < NSEC; s++) begin
      chk({req, " sts"}, 64'(sts_o[s*SW +: SW]), 64'(m_sts[s]));
      chk({req, " ena"}, 64'(ena_o[s*SW +: SW]), 64'(m_ena[s]));
    end
    chk({req, " glob"}, 64'(glob_o), 64'(m_glob()));
    chk({req, " irq_n"}, 64'(irq_n_o), 64'(m_irqn));
  endtask

  // one clock cycle of stimulus; model updated from the requirements
  task automatic cyc(input logic [NSEC*SW-1:0] ev, input logic [NSEC-1:0] cw,
                     input logic [NSEC-1:0] ew, input logic [SW-1:0] wd);
    evt_i = ev; clr_we_i = cw; en_we_i = ew; wdata_i = wd;
    m_irqn = ~(|m_glob());
    for (int s = 0; s < NSEC; s++) begin
      m_sts[s] = (m_sts[s] & ~(cw[s] ? wd : '0)) | ev[s*SW +: SW];
      if (ew[s]) m_ena[s] = wd;
    end
    @(negedge clk);
    evt_i = '0; clr_we_i = '0; en_we_i = '0; wdata_i = '0;
  endtask

  task automatic t_reset();
    for (int s = 0; s < NSEC; s++) begin m_sts[s] = '0; m_ena[s] = '0; end
    m_irqn = 1'b1;
    chk_all("R9 during reset");
    @(negedge clk); rst_n = 1'b1;
    cyc('0, '0, '0, '0);
    chk_all("R9 after reset");
  endtask

  task automatic t_latch_disabled();
    cyc(32'h0000_0500, '0, '0, '0);   // AV transmitter, bits 0 and 2
    chk_all("R4 latch while disabled");
    chk("R1 set visible", 64'(sts_o[15:8]), 64'h05);
    cyc('0, '0, '0, '0);
    chk_all("R1 no spurious set");
  endtask

  task automatic t_enable_late();
    cyc('0, '0, 4'b0010, 8'h04);
    chk_all("R4 enable raises summary");
    chk("R6 bit1 is AV transmitter", 64'(glob_o), 64'h2);
    cyc('0, '0, '0, '0);
    chk("R8 irq low", 64'(irq_n_o), 64'h0);
  endtask

  task automatic t_clear();
    cyc('0, 4'b0010, '0, 8'h04);
    chk_all("R2 clear one bit keeps other");
    chk("R7 summary drops without ack", 64'(glob_o), 64'h0);
    cyc('0, '0, '0, '0);
    chk("R8 irq released", 64'(irq_n_o), 64'h1);
    cyc('0, 4'b0010, '0, 8'h00);
    chk_all("R2 write of zero keeps bit");
  endtask

  task automatic t_disable();
    cyc(32'h8000_0000, '0, 4'b1000, 8'h80);
    chk_all("R6 async section");
    chk("R6 bit3", 64'(glob_o), 64'h8);
    cyc('0, '0, 4'b1000, 8'h00);
    chk_all("R7 disable clears summary, R5 status untouched");
    cyc('0, '0, '0, '0);
    chk_all("R8 pin follows disable");
  endtask

  task automatic t_priority();
    cyc('0, '0, 4'b0001, 8'h03);
    cyc(32'h0000_0001, 4'b0001, '0, 8'h01);
    chk_all("R3 event beats clear");
    chk("R3 link bit0", 64'(sts_o[0]), 64'h1);
    cyc(32'h0000_0002, 4'b0001, '0, 8'h01);
    chk_all("R3 clear other bit with event");
  endtask

  task automatic t_independent();
    cyc(32'h0011_0000, '0, 4'b0100, 8'hFF);
    chk_all("R6 AV receiver summary");
    cyc('0, 4'b0100, 4'b0100, 8'hFF);
    chk_all("R10 writes to section 2 isolate others");
    cyc('0, 4'b1011, '0, 8'hFF);
    cyc('0, '0, 4'b1111, 8'h00);
    cyc('0, '0, '0, '0);
    chk_all("R7 all cleared, R8 released");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latch_disabled();
    t_enable_late();
    t_clear();
    t_disable();
    t_priority();
    t_independent();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule